// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Bus Engine

This block is the bit-level slave front end of a two-wire serial memory. It brings the clock line and the data line into the system clock domain, recognises START, repeated START and STOP conditions, and moves eight-bit words in and out most significant bit first. It drives the data line only by pulling it low through an open-drain enable. It never drives the line high.

The engine compares the device-address word with a fixed prefix and two strap pins. It acknowledges each accepted word in the ninth clock. It reports received bytes and bus events to a transaction controller, which sits outside this block and owns the memory array and the address counter. In a read, the controller supplies the byte to send, and the engine pulses a request each time it takes one. While the controller signals that an internal write cycle is running, the engine does not acknowledge its address. A master can therefore poll for completion by repeatedly sending the address.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, sda_oe_o is 0 and none of rx_valid_o, rd_req_o, addr_hit_o, start_o or stop_o pulses while the bus stays idle.
- R2: An SDA fall while SCL is high produces one start_o pulse; this includes a repeated START. An SDA rise while SCL is high produces one stop_o pulse.
- R3: The first word after a START is taken MSB first. Bits 7..3 must be 1,0,1,0,0 and bits 2..1 must equal strap_i[1:0]. On a match the engine pulls SDA low in the ninth clock and pulses addr_hit_o, and rw_o takes bit 0 (1 = read, 0 = write).
- R4: On a prefix or strap mismatch there is no acknowledge. The engine then gives no further acknowledge and no rx_valid_o until the next START.
- R5: If busy_i is high when the address word completes, the address is not acknowledged. Once busy_i is low again, the same address is acknowledged.
- R6: In a write, every data byte is acknowledged and produces one rx_valid_o pulse with the byte on rx_data_o (first bit received = bit 7). This holds for any number of bytes.
- R7: In a read, rd_data_i is sent MSB first. It is loaded on the SCL fall that ends the preceding acknowledge bit, and each load gives one rd_req_o pulse.
- R8: After a read byte, a master acknowledge (SDA low in the ninth clock) makes the engine send the next byte. A master non-acknowledge releases the line, and no more bytes are sent or requested until the next START.
- R9: A repeated START in the middle of a word discards the partial word and returns the engine to the address phase.
- R10: A STOP returns the engine to idle with SDA released. Words clocked after it, without a START, are neither acknowledged nor delivered.
- R11: sda_oe_o is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Chip-select strap pins |
| busy_i | input | 1 | Internal write cycle running |
| rd_data_i | input | 8 | Next byte to send in a read |
| rd_req_o | output | 1 | Pulse: rd_data_i has been taken |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | Pulse: rx_data_o holds a new byte |
| addr_hit_o | output | 1 | Pulse: device address accepted |
| rw_o | output | 1 | Direction of the accepted address, 1 = read |
| start_o | output | 1 | Pulse on START or repeated START |
| stop_o | output | 1 | Pulse on STOP |

## Verification
The hardest situations to reach are bus conditions that fall in the middle of a word: a repeated START after a few data bits, and a STOP partway through a write byte. To reach them, the bench master clocks individual bits and then issues the condition while SCL is low. It then checks that the engine re-enters the address phase, or stays deaf until the next START. A master non-acknowledge followed by further clocking, with no STOP in between, shows that the engine has really released the line and stopped requesting bytes.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int DATA_W   = 8;
  localparam int PREFIX_W = 5;
  localparam int STRAP_W  = 2;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_MACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] ff_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      ff_q   <= {ff_q[STAGES-2:0], line_i};
      prev_q <= ff_q[STAGES-1];
    end
  end

  assign lvl_o  = ff_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic scl_lvl_i,
  input  logic scl_rise_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_steady_hi;
  // SCL must already have been high, not just risen
  assign scl_steady_hi = scl_lvl_i & ~scl_rise_i;
  assign start_o = scl_steady_hi & sda_fall_i;
  assign stop_o  = scl_steady_hi & sda_rise_i;
endmodule

// File: rtl/twi_word_fsm.sv
module twi_word_fsm
  import twi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_lvl_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               sda_lvl_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               rd_req_o,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               rx_valid_o,
  output logic               addr_hit_o,
  output logic               rw_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  twi_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_q, oe_q, rw_q, mack_q;
  logic [DATA_W-1:0] sreg_q, txreg_q;
  logic              rx_valid_q, rd_req_q, addr_hit_q;
  logic              addr_match, addr_decide;

  assign addr_match = (sreg_q[DATA_W-1 -: PREFIX_W] == DEV_PREFIX) &&
                      (sreg_q[STRAP_W:1] == strap_i) && !busy_i;
  assign addr_decide = (state_q == ST_ADDR) && scl_fall_i && !ack_q &&
                       (cnt_q == CNT_FULL) && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      ack_q      <= 1'b0;
      oe_q       <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sreg_q     <= '0;
      txreg_q    <= '0;
      rx_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      addr_hit_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      addr_hit_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        ack_q   <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && !ack_q && cnt_q != CNT_FULL) begin
              sreg_q <= {sreg_q[DATA_W-2:0], sda_lvl_i};
              cnt_q  <= cnt_q + 1'b1;
            end else if (scl_fall_i && ack_q) begin
              ack_q <= 1'b0;
              cnt_q <= '0;
              if (state_q == ST_ADDR && rw_q) begin
                state_q  <= ST_RD;
                txreg_q  <= {rd_data_i[DATA_W-2:0], 1'b0};
                oe_q     <= ~rd_data_i[DATA_W-1];
                rd_req_q <= 1'b1;
              end else begin
                state_q <= ST_WR;
                oe_q    <= 1'b0;
              end
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              if (state_q == ST_WR) begin
                ack_q      <= 1'b1;
                oe_q       <= 1'b1;
                rx_valid_q <= 1'b1;
              end else if (addr_match) begin
                ack_q      <= 1'b1;
                oe_q       <= 1'b1;
                rw_q       <= sreg_q[0];
                addr_hit_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
              end
            end
          end
          ST_RD: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
              cnt_q   <= '0;
            end else if (scl_fall_i && cnt_q != '0) begin
              oe_q    <= ~txreg_q[DATA_W-1];
              txreg_q <= {txreg_q[DATA_W-2:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
              cnt_q  <= CNT_W'(1);
            end else if (scl_fall_i && cnt_q != '0) begin
              cnt_q <= '0;
              if (mack_q) begin
                state_q  <= ST_RD;
                txreg_q  <= {rd_data_i[DATA_W-2:0], 1'b0};
                oe_q     <= ~rd_data_i[DATA_W-1];
                rd_req_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign rd_req_o   = rd_req_q;
  assign rx_data_o  = sreg_q;
  assign rx_valid_o = rx_valid_q;
  assign addr_hit_o = addr_hit_q;
  assign rw_o       = rw_q;

  assert_miss_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_decide && !addr_match |=> state_q == ST_IDLE && !oe_q);
  assert_busy_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_decide && busy_i |=> !oe_q);
  assert_rstart_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_q == ST_ADDR && cnt_q == '0);
  assert_stop_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !oe_q && state_q == ST_IDLE);
  assert_oe_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_lvl_i);
  assert_one_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_q, rd_req_q, addr_hit_q}));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               rd_req_o,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               rx_valid_o,
  output logic               addr_hit_o,
  output logic               rw_o,
  output logic               start_o,
  output logic               stop_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_evt, stop_evt;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  twi_cond_detect u_cond (
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise),
    .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  twi_word_fsm u_fsm (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .start_i(start_evt), .stop_i(stop_evt),
    .strap_i, .busy_i, .rd_data_i,
    .sda_oe_o, .rd_req_o, .rx_data_o, .rx_valid_o, .addr_hit_o, .rw_o
  );

  assign start_o = start_evt;
  assign stop_o  = stop_evt;

  assert_cond_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic busy = 1'b0;
  logic [7:0] rd_data;
  logic sda_oe, rd_req, rx_valid, addr_hit, rw, start_p, stop_p;
  logic [7:0] rx_data;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0, n_hit = 0, n_req = 0, n_rx = 0;
  int exp_start = 0, exp_stop = 0;
  int ptr = 0;
  logic [7:0] exp_q[$];
  logic prev_oe = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem(input int a);
    return 8'(8'hA5 ^ (a * 37));
  endfunction
  assign rd_data = mem(ptr);

  twi_mem_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
    .rd_req_o(rd_req), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .addr_hit_o(addr_hit), .rw_o(rw), .start_o(start_p), .stop_o(stop_p)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model of the event side, compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_p) n_start++;
      if (stop_p) n_stop++;
      if (addr_hit) n_hit++;
      if (rd_req) begin n_req++; ptr++; end
      if (sda_oe && !prev_oe && m_scl)
        chk(0, "R11 oe rose while SCL high", 1, 0);
      if (rx_valid) begin
        n_rx++;
        if (exp_q.size() == 0) chk(0, "R4/R6 unexpected rx byte", int'(rx_data), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R6 rx byte", int'(rx_data), int'(e));
        end
      end
      prev_oe <= sda_oe;
    end
  end

  task automatic wq(); repeat (Q) @(posedge clk); endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wq();
    m_scl = 1'b1; wq();
    r = sda_bus; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
    exp_start++;
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
    exp_stop++;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic mack);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(~mack, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] d;
    int base;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(sda_oe == 0 && n_start == 0 && n_stop == 0 && n_hit == 0 && n_req == 0 && n_rx == 0,
        "R1 reset idle", int'(sda_oe), 0);

    // write 5 bytes
    do_start();
    wr_byte(8'hA4, ack);
    chk(ack == 1, "R3 write address ack", int'(ack), 1);
    chk(n_hit == 1 && rw == 0, "R3 addr_hit/rw write", int'(rw), 0);
    for (int i = 0; i < 5; i++) begin
      d = 8'(8'h3C + i * 17);
      exp_q.push_back(d);
      wr_byte(d, ack);
      chk(ack == 1, "R6 data ack", int'(ack), 1);
    end
    do_stop();
    chk(exp_q.size() == 0 && n_rx == 5, "R6 rx count", n_rx, 5);
    chk(n_start == exp_start && n_stop == exp_stop, "R2 start/stop counts", n_start, exp_start);

    // wrong prefix
    do_start();
    wr_byte(8'hB4, ack);
    chk(ack == 0, "R4 prefix mismatch no ack", int'(ack), 0);
    wr_byte(8'h11, ack);
    chk(ack == 0 && n_rx == 5, "R4 deaf after mismatch", int'(ack), 0);
    do_stop();

    // wrong strap
    do_start();
    wr_byte(8'hA2, ack);
    chk(ack == 0 && n_hit == 1, "R4 strap mismatch no ack", int'(ack), 0);
    do_stop();

    // busy polling
    busy = 1'b1;
    do_start();
    wr_byte(8'hA4, ack);
    chk(ack == 0, "R5 busy no ack", int'(ack), 0);
    do_stop();
    busy = 1'b0;
    do_start();
    wr_byte(8'hA4, ack);
    chk(ack == 1, "R5 ack after busy clears", int'(ack), 1);
    do_stop();

    // sequential read
    base = ptr;
    do_start();
    wr_byte(8'hA5, ack);
    chk(ack == 1 && rw == 1, "R3 read address ack rw", int'(rw), 1);
    for (int i = 0; i < 3; i++) begin
      rd_byte(d, i < 2);
      chk(d == mem(base + i), "R7 read byte", int'(d), int'(mem(base + i)));
    end
    chk(n_req == 3, "R8 requests after nack", n_req, 3);
    rd_byte(d, 1'b0);
    chk(d == 8'hFF && n_req == 3, "R8 line released after nack", int'(d), 8'hFF);
    do_stop();

    // repeated start mid-word
    do_start();
    wr_byte(8'hA4, ack);
    clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b0, r);
    do_start();
    base = ptr;
    wr_byte(8'hA5, ack);
    chk(ack == 1, "R9 address after repeated start", int'(ack), 1);
    rd_byte(d, 1'b0);
    chk(d == mem(base), "R9 read after repeated start", int'(d), int'(mem(base)));
    chk(n_rx == 5, "R9 partial word dropped", n_rx, 5);
    do_stop();

    // stop mid-write
    do_start();
    wr_byte(8'hA4, ack);
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
    do_stop();
    m_scl = 1'b0; wq();
    wr_byte(8'h5A, ack);
    chk(ack == 0 && n_rx == 5 && sda_oe == 0, "R10 idle after stop", int'(ack), 0);
    m_scl = 1'b1; wq();
    chk(n_start == exp_start && n_stop == exp_stop, "R2 final start/stop counts", n_stop, exp_stop);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule